// File: doc/BRIEF.md
# Trigger Event Packet Formatter

This block turns each accepted trigger into a fixed ten-word event record. It sends the record one 32-bit word at a time on a valid/ready stream that feeds a datagram transmitter. When a strobe arrives and sending is enabled, the block takes a snapshot of the timestamp, the three event counters, the source bitmap and the masked NIM and ESATA input bits. It then plays the snapshot out in a fixed order. A leading sequence number and tagged header and footer words let the receiver check that each record is whole.

Only one record is in flight at a time. A strobe that arrives while a record is still being sent is not queued. It is counted in a drop counter that the surrounding logic can read. Backpressure from the sink stalls the stream and no word is lost.

Top module: `evpkt_fmt`

## Requirements
- R1: After a synchronous reset, `tx_valid`, `tx_last` and `drop_cnt` are 0, and the sequence number of the first record is 0.
- R2: A record is exactly ten words, in this order by index: 0 sequence number, 1 header, 2 timestamp, 3 accepted count, 4 input count, 5 pulser count, 6 source bitmap, 7 masked NIM bits, 8 masked ESATA bits, 9 footer.
- R3: The header is {4'h8, accepted_count[27:0]} and the footer is {4'h9, accepted_count[27:0]}. Bits 31:28 hold the tag.
- R4: Word 0 holds the sequence number. It rises by one for each record whose footer has been accepted by the sink.
- R5: All payload values are captured on the clock edge at which the strobe is accepted. Later changes on the payload inputs do not alter the record.
- R6: Word 7 is `nim_bits & nim_mask` and word 8 is `esata_bits & esata_mask`, both taken at capture.
- R7: A strobe with `send_en` low is ignored. No record starts and `drop_cnt` does not change.
- R8: `send_en` only gates the start of a record. Clearing it during a record does not cut the record short.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_valid` and `tx_last` hold their values into the next cycle.
- R10: `tx_last` is high only together with the footer word (index 9).
- R11: A strobe with `send_en` high that arrives while a record is busy is dropped and adds one to `drop_cnt`. The busy window runs up to and includes the edge at which the footer is accepted.
- R12: Word 0 becomes valid on the cycle after the strobe is accepted. `tx_valid` falls on the edge that accepts the footer, and a strobe on the next edge starts a new record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_en | input | 1 | Allows new records to start |
| trig_stb | input | 1 | Accepted-trigger strobe, one cycle |
| trig_ts | input | 32 | Trigger timestamp |
| cnt_accept | input | 32 | Accepted trigger count |
| cnt_in | input | 32 | Input trigger count |
| cnt_pulser | input | 32 | Pulser trigger count |
| src_map | input | 32 | Trigger source bitmap |
| nim_bits | input | 32 | NIM input bits |
| nim_mask | input | 32 | NIM bit mask |
| esata_bits | input | 32 | ESATA input bits |
| esata_mask | input | 32 | ESATA bit mask |
| tx_ready | input | 1 | Sink ready |
| tx_data | output | 32 | Stream word |
| tx_valid | output | 1 | Stream word valid |
| tx_last | output | 1 | Marks the footer word |
| drop_cnt | output | 16 | Number of strobes dropped while busy |

## Verification
The payload inputs are driven with new random values on every cycle. A match between each word and the values present at the strobe edge therefore shows that the snapshot was taken at capture and not at send time. Sink readiness is tried at always-ready, at about half the time and at rarely-ready. This separates lost or repeated words from correct stalls.

Random strobes with `send_en` mostly high land inside records and at their edges, which exercises the drop counter. Directed cases cover the following:
- a strobe while disabled
- `send_en` cleared in the middle of a record
- a strobe on the footer edge, which must be dropped
- a strobe on the edge right after the footer, which must start a new record

// File: rtl/evpkt_pkg.sv
package evpkt_pkg;
  localparam int WORD_W  = 32;
  localparam int TAG_W   = 4;
  localparam int LOW_W   = WORD_W - TAG_W;
  localparam int NWORDS  = 10;
  localparam int IDX_W   = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NWORDS - 1);
  localparam logic [TAG_W-1:0] TAG_HEAD = 4'h8;
  localparam logic [TAG_W-1:0] TAG_FOOT = 4'h9;

  typedef struct packed {
    logic [WORD_W-1:0] ts;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] tin;
    logic [WORD_W-1:0] pulser;
    logic [WORD_W-1:0] srcmap;
    logic [WORD_W-1:0] nim;
    logic [WORD_W-1:0] esata;
  } snap_t;

  // Word for record index 1..9; index 0 (sequence number) is handled outside.
  function automatic logic [WORD_W-1:0] word_at(input logic [IDX_W-1:0] idx,
                                                 input snap_t s);
    logic [WORD_W-1:0] w;
    case (idx)
      IDX_W'(1): w = {TAG_HEAD, s.acc[LOW_W-1:0]};
      IDX_W'(2): w = s.ts;
      IDX_W'(3): w = s.acc;
      IDX_W'(4): w = s.tin;
      IDX_W'(5): w = s.pulser;
      IDX_W'(6): w = s.srcmap;
      IDX_W'(7): w = s.nim;
      IDX_W'(8): w = s.esata;
      IDX_W'(9): w = {TAG_FOOT, s.acc[LOW_W-1:0]};
      default:   w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/evpkt_capture.sv
module evpkt_capture
  import evpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] trig_ts,
  input  logic [WORD_W-1:0] cnt_accept,
  input  logic [WORD_W-1:0] cnt_in,
  input  logic [WORD_W-1:0] cnt_pulser,
  input  logic [WORD_W-1:0] src_map,
  input  logic [WORD_W-1:0] nim_bits,
  input  logic [WORD_W-1:0] nim_mask,
  input  logic [WORD_W-1:0] esata_bits,
  input  logic [WORD_W-1:0] esata_mask,
  output snap_t             snap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
    end else if (load) begin
      snap.ts     <= trig_ts;
      snap.acc    <= cnt_accept;
      snap.tin    <= cnt_in;
      snap.pulser <= cnt_pulser;
      snap.srcmap <= src_map;
      snap.nim    <= nim_bits & nim_mask;
      snap.esata  <= esata_bits & esata_mask;
    end
  end

  // R5: snapshot holds whenever no new record is loaded
  a_r5_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(snap));
endmodule

// File: rtl/evpkt_ctrl.sv
module evpkt_ctrl
  import evpkt_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic              en,
  input  logic              ready,
  output logic              start,
  output logic              hs,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] pkt_cnt,
  output logic [DROP_W-1:0] drop_cnt
);
  logic finish;

  assign start  = trig && en && !busy;
  assign hs     = busy && ready;
  assign finish = hs && (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      pkt_cnt <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (finish) begin
      busy    <= 1'b0;
      idx     <= '0;
      pkt_cnt <= pkt_cnt + 1'b1;
    end else if (hs) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      drop_cnt <= '0;
    else if (trig && en && busy)  drop_cnt <= drop_cnt + 1'b1;
  end

  // R11: a strobe while busy is counted once
  a_r11_drop_count: assert property (@(posedge clk) disable iff (rst)
    (trig && en && busy) |=> drop_cnt == $past(drop_cnt) + 1'b1);
  // R7: strobe while disabled does not start a record
  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && trig && !en) |=> !busy && $stable(drop_cnt));
  // R9: no index advance without the sink taking a word
  a_r9_idx_stall: assert property (@(posedge clk) disable iff (rst)
    (busy && !ready) |=> busy && $stable(idx));
endmodule

// File: rtl/evpkt_txreg.sv
module evpkt_txreg
  import evpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              hs,
  input  logic [IDX_W-1:0]  idx,
  input  snap_t             snap,
  input  logic [WORD_W-1:0] pkt_cnt,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              tx_last
);
  logic [IDX_W-1:0] idx_nxt;
  assign idx_nxt = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
    end else if (start) begin
      tx_data  <= pkt_cnt;
      tx_valid <= 1'b1;
      tx_last  <= 1'b0;
    end else if (hs) begin
      if (idx == IDX_LAST) begin
        tx_valid <= 1'b0;
        tx_last  <= 1'b0;
      end else begin
        tx_data <= word_at(idx_nxt, snap);
        tx_last <= (idx_nxt == IDX_LAST);
      end
    end
  end

  // R10: last only on a valid footer word
  a_r10_last_footer: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid && tx_data[WORD_W-1 -: TAG_W] == TAG_FOOT);
  // R3: header word carries its tag
  a_r3_header_tag: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && idx == IDX_W'(1)) |-> tx_data[WORD_W-1 -: TAG_W] == TAG_HEAD);
  // R9: stalled word holds
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !hs) |=> tx_valid && $stable(tx_data) && $stable(tx_last));
endmodule

// File: rtl/evpkt_fmt.sv
module evpkt_fmt
  import evpkt_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_en,
  input  logic              trig_stb,
  input  logic [31:0]       trig_ts,
  input  logic [31:0]       cnt_accept,
  input  logic [31:0]       cnt_in,
  input  logic [31:0]       cnt_pulser,
  input  logic [31:0]       src_map,
  input  logic [31:0]       nim_bits,
  input  logic [31:0]       nim_mask,
  input  logic [31:0]       esata_bits,
  input  logic [31:0]       esata_mask,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  output logic [DROP_W-1:0] drop_cnt
);
  logic              start, hs, busy;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] pkt_cnt;
  snap_t             snap;

  evpkt_ctrl #(.DROP_W(DROP_W)) u_ctrl (
    .clk(clk), .rst(rst), .trig(trig_stb), .en(send_en), .ready(tx_ready),
    .start(start), .hs(hs), .busy(busy), .idx(idx), .pkt_cnt(pkt_cnt),
    .drop_cnt(drop_cnt)
  );

  evpkt_capture u_cap (
    .clk(clk), .rst(rst), .load(start),
    .trig_ts(trig_ts), .cnt_accept(cnt_accept), .cnt_in(cnt_in),
    .cnt_pulser(cnt_pulser), .src_map(src_map),
    .nim_bits(nim_bits), .nim_mask(nim_mask),
    .esata_bits(esata_bits), .esata_mask(esata_mask),
    .snap(snap)
  );

  evpkt_txreg u_tx (
    .clk(clk), .rst(rst), .start(start), .hs(hs), .idx(idx), .snap(snap),
    .pkt_cnt(pkt_cnt), .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last)
  );

  // R12: stream valid tracks the sequencer's busy window
  a_r12_valid_busy: assert property (@(posedge clk) disable iff (rst)
    tx_valid == busy);
  // R4: sequence number steps once per completed record
  a_r4_seq_step: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> pkt_cnt == $past(pkt_cnt) + 1'b1);
  // R8: a record in progress continues regardless of send_en
  a_r8_no_abort: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_last) |=> tx_valid);
endmodule

// File: tb/evpkt_fmt_bench.sv
module evpkt_fmt_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        send_en = 1'b0, trig_stb = 1'b0, tx_ready = 1'b0;
  logic [31:0] trig_ts = '0, cnt_accept = '0, cnt_in = '0, cnt_pulser = '0;
  logic [31:0] src_map = '0, nim_bits = '0, nim_mask = '0, esata_bits = '0, esata_mask = '0;
  logic [31:0] tx_data;
  logic        tx_valid, tx_last;
  logic [15:0] drop_cnt;

  always #5 clk = ~clk;

  evpkt_fmt u_evpkt_fmt (
    .clk(clk), .rst(rst), .send_en(send_en), .trig_stb(trig_stb),
    .trig_ts(trig_ts), .cnt_accept(cnt_accept), .cnt_in(cnt_in),
    .cnt_pulser(cnt_pulser), .src_map(src_map), .nim_bits(nim_bits),
    .nim_mask(nim_mask), .esata_bits(esata_bits), .esata_mask(esata_mask),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .drop_cnt(drop_cnt)
  );

  int checks = 0, fails = 0;
  logic        m_busy = 1'b0;
  int          m_words = 0;
  logic [31:0] m_seq = '0;
  logic [15:0] m_drop = '0;
  logic [31:0] exp_w [10];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data = '0;
  logic        prev_last = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string word_req(input int k);
    if (k == 0) return "R4 seq word";
    if (k == 1 || k == 9) return "R3 tag word";
    if (k == 7 || k == 8) return "R6 masked word";
    return "R2/R5 payload word";
  endfunction

  // Expected record built from the inputs present at the capture edge
  function automatic void build_exp();
    exp_w[0] = m_seq;
    exp_w[1] = {4'h8, cnt_accept[27:0]};
    exp_w[2] = trig_ts;
    exp_w[3] = cnt_accept;
    exp_w[4] = cnt_in;
    exp_w[5] = cnt_pulser;
    exp_w[6] = src_map;
    exp_w[7] = nim_bits & nim_mask;
    exp_w[8] = esata_bits & esata_mask;
    exp_w[9] = {4'h9, cnt_accept[27:0]};
  endfunction

  task automatic step(input logic t, input logic e, input int rdy_pct);
    @(negedge clk);
    chk(tx_valid == m_busy, "R7/R8/R12 valid window", {31'b0, tx_valid}, {31'b0, m_busy});
    chk(drop_cnt == m_drop, "R11 drop count", {16'b0, drop_cnt}, {16'b0, m_drop});
    if (prev_stall)
      chk(tx_valid && tx_data == prev_data && tx_last == prev_last,
          "R9 stall hold", tx_data, prev_data);
    trig_stb   = t;
    send_en    = e;
    tx_ready   = ($urandom % 100) < rdy_pct;
    trig_ts    = $urandom; cnt_accept = $urandom; cnt_in = $urandom;
    cnt_pulser = $urandom; src_map = $urandom; nim_bits = $urandom;
    nim_mask   = $urandom; esata_bits = $urandom; esata_mask = $urandom;
    if (t && e) begin
      if (m_busy) m_drop++;
      else begin
        build_exp();
        m_busy = 1'b1;
        m_words = 0;
      end
    end
    if (tx_valid && tx_ready && m_words < 10) begin
      chk(tx_data == exp_w[m_words], word_req(m_words), tx_data, exp_w[m_words]);
      chk(tx_last == (m_words == 9), "R10 last flag", {31'b0, tx_last},
          {31'b0, m_words == 9});
      m_words++;
      if (m_words == 10) begin
        m_busy = 1'b0;
        m_seq++;
      end
    end
    prev_stall = tx_valid && !tx_ready;
    prev_data  = tx_data;
    prev_last  = tx_last;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!tx_valid && !tx_last, "R1 reset outputs", {30'b0, tx_valid, tx_last}, 32'h0);
    chk(drop_cnt == 16'h0, "R1 reset drop", {16'b0, drop_cnt}, 32'h0);

    // R7: strobes while disabled are ignored
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 100);
    // R1/R4: first record carries sequence 0, sink always ready
    step(1'b1, 1'b1, 100);
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1, 100);
    // R11/R12: strobe on the footer edge is dropped, next edge starts
    step(1'b1, 1'b1, 100);
    step(1'b1, 1'b1, 100);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 100);
    // R8: send_en cleared mid-record, record still completes
    step(1'b1, 1'b1, 50);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 50);
    // R9: heavy backpressure
    step(1'b1, 1'b1, 15);
    for (int i = 0; i < 150; i++) step(($urandom % 10) == 0, 1'b1, 15);
    // Random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) == 0, ($urandom % 10) != 0, (i / 1000 == 0) ? 100 :
           (i / 1000 == 1) ? 50 : 20);
    // Drain
    for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 100);
    chk(!m_busy, "R12 drained", {31'b0, m_busy}, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule